// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers sixteen level-sensitive interrupt requests, ranks them by fixed priority and raises one interrupt line toward the processor. It can act as the master of a two-level cascade. Any request line can be marked as carrying the output of a subordinate controller. For such a line, the acknowledge read does not return a vector. It returns a negative table index that the processor uses to find and address the subordinate.

The processor takes an interrupt by pulsing an acknowledge-read strobe and sampling the byte on `rdByte` in that same cycle. For an ordinary line that byte is a vector: a programmable 7-bit base plus the line number. For a cascaded line it is the line number minus sixteen, in two's complement. At the clock edge that ends the strobe, the winning line enters the in-service set. When its handler finishes, the processor pulses an end-of-interrupt strobe. The block returns the same byte again, so the processor can pass the completion notice on to a subordinate. It then clears the highest-priority in-service line, and the lines still pending compete again.

Three registers configure the block: a mask, a cascade-line set and a vector base. All three are loaded through a small write port.

Top module: `cascade_irq_master`

## Requirements
- R1: After reset, every mask bit is set, no line is cascaded, the vector base is 0, nothing is in service, and `irqOut` is low.
- R2: `irqOut` is high exactly when some line is requesting, unmasked, not in service, and has a smaller number than every line in service.
- R3: Priority is fixed. Line 0 is highest and line 15 is lowest. The acknowledge byte always belongs to the lowest-numbered eligible line.
- R4: For a non-cascaded line n, the acknowledge byte is {0, (base + n) mod 128}. Bit 7 is clear.
- R5: For a cascaded line n, the acknowledge byte is n − 16 in 8-bit two's complement (0xF0 + n). Bit 7 is set.
- R6: The clock edge that ends an acknowledge strobe places the winning line in service. That line, and every lower-priority line, then stop raising `irqOut`. Higher-priority lines can still raise it.
- R7: An end-of-interrupt read returns the byte that the highest-priority in-service line returned when it was acknowledged. The edge that ends the strobe clears that line's in-service bit.
- R8: A set mask bit keeps its line from raising `irqOut` or winning an acknowledge.
- R9: An acknowledge with no eligible line, or an end-of-interrupt with nothing in service, returns 0x7F and changes no state.
- R10: Writes take effect at the clock edge and use `wrSel` as follows: 0 loads the mask from `wrData`, 1 loads the cascade-line set from `wrData`, and 2 loads the base from `wrData[6:0]`. Code 3 changes nothing. With no read strobe active, `rdByte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 16 | Level request per line |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 mask, 1 cascade set, 2 base, 3 none) |
| wrData | input | 16 | Write data |
| ackRd | input | 1 | Acknowledge read strobe |
| eoiRd | input | 1 | End-of-interrupt read strobe (ignored while ackRd is high) |
| irqOut | output | 1 | Interrupt request to the processor |
| rdByte | output | 8 | Byte returned during the active read strobe |

## Verification
The bench builds the block with its default values: sixteen lines and a 7-bit base. With these values, both ends of the cascade index range are reachable, namely 0xF0 for line 0 and 0xFF for line 15. The base can be set to 127, so that the vector sum wraps past 128. The nesting cases covered are a higher line pre-empting a cascaded line in service, end-of-interrupt unwinding two levels in priority order, and a reset that arrives while a line is in service.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_CASC = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  typedef enum logic [1:0] {RD_NONE, RD_ACK, RD_EOI, RD_SPUR} rdMode_t;

  typedef struct packed {
    logic    ackTake;
    logic    eoiTake;
    logic    wrMask;
    logic    wrCasc;
    logic    wrBase;
    rdMode_t rdMode;
  } cirqStrobes_t;
endpackage

// File: rtl/cirq_ctrl.sv
module cirq_ctrl
  import cirq_pkg::*;
(
  input  logic         ackRd,
  input  logic         eoiRd,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic         hasWinner,
  input  logic         hasActive,
  output cirqStrobes_t strobes
);
  logic eoiOnly;

  always_comb begin
    eoiOnly = eoiRd && !ackRd;
    strobes = '0;
    strobes.rdMode  = RD_NONE;
    strobes.wrMask  = wrEn && (wrSel == SEL_MASK);
    strobes.wrCasc  = wrEn && (wrSel == SEL_CASC);
    strobes.wrBase  = wrEn && (wrSel == SEL_BASE);
    strobes.ackTake = ackRd && hasWinner;
    strobes.eoiTake = eoiOnly && hasActive;
    if (ackRd) begin
      strobes.rdMode = hasWinner ? RD_ACK : RD_SPUR;
    end else if (eoiOnly) begin
      strobes.rdMode = hasActive ? RD_EOI : RD_SPUR;
    end
  end
endmodule

// File: rtl/cirq_datapath.sv
module cirq_datapath
  import cirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int BASE_W    = 7,
  parameter int BYTE_W    = BASE_W + 1,
  parameter int LIDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [NUM_LINES-1:0] wrData,
  input  cirqStrobes_t         strobes,
  output logic                 hasWinner,
  output logic                 hasActive,
  output logic [BYTE_W-1:0]    rdByte
);
  localparam logic [BYTE_W-1:0] SPURIOUS = {1'b0, {BASE_W{1'b1}}};

  logic [NUM_LINES-1:0] maskReg, cascReg, inSvc;
  logic [BASE_W-1:0]    baseReg;
  logic [NUM_LINES-1:0] aboveActive, candidate;
  logic [LIDX_W-1:0]    winIdx, actIdx;

  function automatic logic [LIDX_W-1:0] lowestSet(input logic [NUM_LINES-1:0] v);
    logic [LIDX_W-1:0] idx;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) idx = LIDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [BYTE_W-1:0] lineByte(input logic [LIDX_W-1:0] idx,
                                                 input logic [NUM_LINES-1:0] casc,
                                                 input logic [BASE_W-1:0] base);
    if (casc[idx]) return BYTE_W'(idx) - BYTE_W'(NUM_LINES);
    return {1'b0, base + BASE_W'(idx)};
  endfunction

  assign hasActive = |inSvc;
  assign actIdx    = lowestSet(inSvc);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_above
    assign aboveActive[g] = !hasActive || (LIDX_W'(g) < actIdx);
  end

  assign candidate = irqReq & ~maskReg & ~inSvc & aboveActive;
  assign hasWinner = |candidate;
  assign winIdx    = lowestSet(candidate);

  always_comb begin
    unique case (strobes.rdMode)
      RD_ACK:  rdByte = lineByte(winIdx, cascReg, baseReg);
      RD_EOI:  rdByte = lineByte(actIdx, cascReg, baseReg);
      RD_SPUR: rdByte = SPURIOUS;
      default: rdByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '1;
      cascReg <= '0;
      baseReg <= '0;
    end else begin
      if (strobes.wrMask) maskReg <= wrData;
      if (strobes.wrCasc) cascReg <= wrData;
      if (strobes.wrBase) baseReg <= wrData[BASE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvc <= '0;
    end else if (strobes.ackTake) begin
      inSvc[winIdx] <= 1'b1;
    end else if (strobes.eoiTake) begin
      inSvc[actIdx] <= 1'b0;
    end
  end
endmodule

// File: rtl/cascade_irq_master.sv
module cascade_irq_master
  import cirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int BASE_W    = 7,
  localparam int BYTE_W   = BASE_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic                 ackRd,
  input  logic                 eoiRd,
  output logic                 irqOut,
  output logic [BYTE_W-1:0]    rdByte
);
  cirqStrobes_t strobes;
  logic hasWinner, hasActive;

  cirq_ctrl u_ctrl (
    .ackRd(ackRd), .eoiRd(eoiRd), .wrEn(wrEn), .wrSel(wrSel),
    .hasWinner(hasWinner), .hasActive(hasActive), .strobes(strobes)
  );

  cirq_datapath #(.NUM_LINES(NUM_LINES), .BASE_W(BASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .wrData(wrData),
    .strobes(strobes), .hasWinner(hasWinner), .hasActive(hasActive),
    .rdByte(rdByte)
  );

  assign irqOut = hasWinner;
endmodule

// File: rtl/cascade_irq_checker.sv
module cascade_irq_checker #(
  parameter int NUM_LINES = 16,
  parameter int BYTE_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqReq,
  input logic                 wrEn,
  input logic [1:0]           wrSel,
  input logic [NUM_LINES-1:0] wrData,
  input logic                 ackRd,
  input logic                 eoiRd,
  input logic                 irqOut,
  input logic [BYTE_W-1:0]    rdByte
);
  // R9
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !irqOut) |-> rdByte == {1'b0, {(BYTE_W-1){1'b1}}});

  // R5
  casc_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && irqOut && rdByte[BYTE_W-1]) |-> rdByte[BYTE_W-1:BYTE_W-4] == 4'hF);

  // R8
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && (&wrData) && !ackRd && !eoiRd) |=> !irqOut);

  // R10
  idle_byte_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ackRd && !eoiRd) |-> rdByte == '0);

  // R10
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ackRd && !eoiRd && (!wrEn || wrSel == 2'd3)) ##1 $stable(irqReq) |-> $stable(irqOut));
endmodule

bind cascade_irq_master cascade_irq_checker #(.NUM_LINES(NUM_LINES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .ackRd(ackRd), .eoiRd(eoiRd), .irqOut(irqOut), .rdByte(rdByte)
);

// File: tb/test_cascade_irq_master.sv
module test_cascade_irq_master;
  localparam int N = 16;
  localparam logic [1:0] IDLE = 2'd0, WR = 2'd1, ACK = 2'd2, EOI = 2'd3;
  // {req tag(4), op(2), sel(2), data(16), req(16), expIrq(1), expByte(8)} = 49 bits
  localparam int NV = 34;
  localparam logic [48:0] VEC [NV] = '{
    {4'd1,  IDLE, 2'd0, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R1 quiet after reset
    {4'd1,  IDLE, 2'd0, 16'h0000, 16'h0001, 1'b0, 8'h00}, // R1 mask reset all set
    {4'd9,  ACK,  2'd0, 16'h0000, 16'h0001, 1'b0, 8'h7F}, // R9 spurious ack
    {4'd10, WR,   2'd0, 16'h0000, 16'h0001, 1'b0, 8'h00}, // R10 unmask all
    {4'd2,  IDLE, 2'd0, 16'h0000, 16'h0001, 1'b1, 8'h00}, // R2 request raises irq
    {4'd10, WR,   2'd2, 16'h0010, 16'h0001, 1'b1, 8'h00}, // R10 base = 16
    {4'd3,  ACK,  2'd0, 16'h0000, 16'h0021, 1'b1, 8'h10}, // R3 R4 line 0 wins over 5
    {4'd6,  IDLE, 2'd0, 16'h0000, 16'h0021, 1'b0, 8'h00}, // R6 line 5 blocked
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0021, 1'b0, 8'h10}, // R7 echo line 0 vector
    {4'd7,  IDLE, 2'd0, 16'h0000, 16'h0021, 1'b1, 8'h00}, // R7 in-service cleared
    {4'd10, WR,   2'd1, 16'h0020, 16'h0020, 1'b1, 8'h00}, // R10 line 5 cascaded
    {4'd5,  ACK,  2'd0, 16'h0000, 16'h0020, 1'b1, 8'hF5}, // R5 5-16 = -11
    {4'd6,  IDLE, 2'd0, 16'h0000, 16'h0021, 1'b1, 8'h00}, // R6 line 0 pre-empts
    {4'd6,  ACK,  2'd0, 16'h0000, 16'h0021, 1'b1, 8'h10}, // R6 nested ack line 0
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'h10}, // R7 unwinds line 0 first
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'hF5}, // R7 then cascaded line 5
    {4'd9,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'h7F}, // R9 nothing in service
    {4'd10, WR,   2'd2, 16'h007F, 16'h0000, 1'b0, 8'h00}, // R10 base = 127
    {4'd10, WR,   2'd1, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R10 no cascades
    {4'd4,  ACK,  2'd0, 16'h0000, 16'h0004, 1'b1, 8'h01}, // R4 127+2 wraps to 1
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'h01}, // R7 echo wrapped vector
    {4'd10, WR,   2'd3, 16'hFFFF, 16'h0004, 1'b1, 8'h00}, // R10 code 3 write
    {4'd10, IDLE, 2'd0, 16'h0000, 16'h0004, 1'b1, 8'h00}, // R10 mask untouched
    {4'd8,  WR,   2'd0, 16'h0004, 16'h0004, 1'b1, 8'h00}, // R8 mask line 2
    {4'd8,  IDLE, 2'd0, 16'h0000, 16'h0004, 1'b0, 8'h00}, // R8 line 2 suppressed
    {4'd4,  ACK,  2'd0, 16'h0000, 16'h8004, 1'b1, 8'h0E}, // R4 line 15: 127+15 -> 14
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'h0E}, // R7
    {4'd10, WR,   2'd1, 16'h8001, 16'h0000, 1'b0, 8'h00}, // R10 lines 0 and 15 cascaded
    {4'd5,  ACK,  2'd0, 16'h0000, 16'h8000, 1'b1, 8'hFF}, // R5 line 15 -> -1
    {4'd5,  ACK,  2'd0, 16'h0000, 16'h8001, 1'b1, 8'hF0}, // R5 line 0 -> -16
    {4'd9,  ACK,  2'd0, 16'h0000, 16'h8001, 1'b0, 8'h7F}, // R9 both in service
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'hF0}, // R7
    {4'd7,  EOI,  2'd0, 16'h0000, 16'h0000, 1'b0, 8'hFF}, // R7
    {4'd2,  IDLE, 2'd0, 16'h0000, 16'h8000, 1'b1, 8'h00}  // R2
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] irqReq = '0, wrData = '0;
  logic wrEn = 1'b0, ackRd = 1'b0, eoiRd = 1'b0;
  logic [1:0] wrSel = '0;
  logic irqOut;
  logic [7:0] rdByte;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cascade_irq_master i_cascade_irq_master (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .ackRd(ackRd), .eoiRd(eoiRd), .irqOut(irqOut), .rdByte(rdByte)
  );

  task automatic drive(input logic [1:0] op, input logic [1:0] sel,
                       input logic [15:0] data, input logic [15:0] req);
    @(negedge clk);
    wrEn = (op == WR); ackRd = (op == ACK); eoiRd = (op == EOI);
    wrSel = sel; wrData = data; irqReq = req;
    #1;
  endtask

  task automatic check(input int tag, input logic expIrq, input logic [7:0] expByte);
    applied++;
    if (irqOut !== expIrq || rdByte !== expByte) begin
      bad++;
      $display("FAIL R%0d: irqOut=%b rdByte=%h, expected irqOut=%b rdByte=%h",
               tag, irqOut, rdByte, expIrq, expByte);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][44:43], VEC[i][42:41], VEC[i][40:25], VEC[i][24:9]);
      check(int'(VEC[i][48:45]), VEC[i][8], VEC[i][7:0]);
    end
    // Directed: reset while a line is in service (R1)
    drive(ACK, 2'd0, 16'h0000, 16'h8000);
    check(5, 1'b1, 8'hFF);           // R5 line 15 into service
    @(negedge clk);
    rstN = 1'b0; ackRd = 1'b0; irqReq = 16'h8000;
    @(negedge clk);
    rstN = 1'b1; #1;
    check(1, 1'b0, 8'h00);           // R1 mask set again
    drive(WR, 2'd0, 16'h0000, 16'h8000);
    drive(IDLE, 2'd0, 16'h0000, 16'h8000);
    check(1, 1'b1, 8'h00);           // R1 in-service cleared by reset
    drive(ACK, 2'd0, 16'h0000, 16'h8000);
    check(1, 1'b1, 8'h0F);           // R1 base 0, cascade cleared
    drive(EOI, 2'd0, 16'h0000, 16'h0000);
    check(7, 1'b0, 8'h0F);           // R7
    drive(IDLE, 2'd0, 16'h0000, 16'h0000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule